// File: doc/BRIEF.md
# Session Credit Vending Controller

This synchronous controller keeps the running money balance for one customer at a vending machine. Each money strobe adds its amount to the balance, and the balance is always visible on an output. A selection strobe names one of four items. The item's price comes from a constant table inside the block. If the balance covers the price, the item is vended and its price is taken off the balance. If the balance does not cover the price, the request is refused and the balance is not touched.

A customer may buy several items in a row from the same balance. When the customer asks to finish, the whole remaining balance is paid out as change on a single-cycle refund pulse. The balance then returns to zero and the controller goes back to idle, ready for the next customer. Vend, refund and refuse indications are single-cycle pulses. All strobes are sampled on the rising clock edge, and results appear on the registered outputs right after that edge.

Top module: `vend_credit_ctrl`

## Requirements
- R1: A money strobe adds `coin_amt_i` to the balance, and the new total is visible on `credit_o` after that clock edge.
- R2: The balance is 8 bits wide. A sum above 255 holds at 255; it does not wrap.
- R3: A selection whose price is less than or equal to the balance raises `vend_o` for one cycle, with `vend_item_o` equal to the selected code. The price is subtracted from the balance, and an exact match leaves the balance at 0.
- R4: A selection whose price is greater than the balance raises `reject_o` for one cycle. It gives no vend, and the balance is left unchanged.
- R5: A finish strobe during a session raises `refund_o` for one cycle, with `refund_amt_o` equal to the whole balance (even when that balance is 0). The balance is then cleared and the controller goes idle. A session starts with the first money strobe after reset or after the last refund. A finish strobe while idle produces no pulse.
- R6: The price table is: code 0 costs 13, code 1 costs 11, code 2 costs 7 and code 3 costs 20.
- R7: When strobes arrive together, finish wins over selection, and selection wins over money. Any lower-ranked strobe in the same cycle is discarded.
- R8: Each of `vend_o`, `refund_o` and `reject_o` stays high for exactly one cycle per request. At most one of the three is high in any cycle, and `refund_amt_o` and `vend_item_o` read 0 outside their pulses.
- R9: Synchronous active-high reset clears the balance, drops all pulses and puts the controller in idle.
- R10: Starting from a balance of 36, two code-0 purchases succeed and leave 10. A following code-1 request is refused with 10 still held.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_stb_i | input | 1 | Money inserted this cycle |
| coin_amt_i | input | 8 | Value of the inserted money |
| sel_stb_i | input | 1 | Item selection this cycle |
| sel_code_i | input | 2 | Selected item code |
| end_stb_i | input | 1 | Customer asks to finish |
| vend_o | output | 1 | One-cycle vend pulse |
| vend_item_o | output | 2 | Item code being vended |
| refund_o | output | 1 | One-cycle change pulse |
| refund_amt_o | output | 8 | Change paid out |
| reject_o | output | 1 | One-cycle refused-selection pulse |
| credit_o | output | 8 | Current balance |

## Verification
The hardest situation to reach from the ports is the set of cycles where strobes collide. The arbitration must drop money that arrives with a finish or a selection, and that dropped amount never shows up on any output. The stimulus drives all three strobes in one cycle, and then selection with money in another cycle. The money amounts are chosen so that a wrongly added amount would change the balance or the refund value that is checked. The bench also reaches saturation by inserting two large amounts, and it takes the balance to exactly zero through an exact-price purchase. It then confirms that a finish in that state still pays out a refund of 0, while a second finish right after it produces no pulse at all.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CREDIT_W = 8;
    localparam int ITEM_W   = 2;
    localparam int N_ITEMS  = 1 << ITEM_W;
    localparam logic [CREDIT_W-1:0] CREDIT_MAX = {CREDIT_W{1'b1}};

    typedef logic [CREDIT_W-1:0] credit_t;
    typedef logic [ITEM_W-1:0]   item_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_COIN,
        CMD_SEL,
        CMD_END
    } cmd_e;

    typedef enum logic {
        ST_IDLE,
        ST_SESSION
    } state_e;

    typedef struct packed {
        cmd_e    cmd;
        credit_t amt;
        item_t   item;
    } req_t;

    function automatic credit_t price_of(input int idx);
        case (idx)
            0:       return credit_t'(13);
            1:       return credit_t'(11);
            2:       return credit_t'(7);
            default: return credit_t'(20);
        endcase
    endfunction

    function automatic credit_t sat_add(input credit_t a, input credit_t b);
        logic [CREDIT_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[CREDIT_W] ? CREDIT_MAX : sum[CREDIT_W-1:0];
    endfunction

endpackage

// File: rtl/vend_arbiter.sv
module vend_arbiter
    import vend_pkg::*;
(
    input  logic    coin_stb_i,
    input  credit_t coin_amt_i,
    input  logic    sel_stb_i,
    input  item_t   sel_code_i,
    input  logic    end_stb_i,
    output req_t    req_o
);

    always_comb begin
        req_o.amt  = coin_amt_i;
        req_o.item = sel_code_i;
        if (end_stb_i)       req_o.cmd = CMD_END;
        else if (sel_stb_i)  req_o.cmd = CMD_SEL;
        else if (coin_stb_i) req_o.cmd = CMD_COIN;
        else                 req_o.cmd = CMD_NONE;
    end

endmodule

// File: rtl/vend_price_lut.sv
module vend_price_lut
    import vend_pkg::*;
(
    input  item_t   code_i,
    output credit_t price_o
);

    credit_t table_q [N_ITEMS];

    for (genvar i = 0; i < N_ITEMS; i++) begin : g_price
        assign table_q[i] = price_of(i);
    end

    assign price_o = table_q[code_i];

endmodule

// File: rtl/vend_credit_unit.sv
module vend_credit_unit
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  req_t    req_i,
    input  credit_t price_i,
    output logic    vend_o,
    output item_t   vend_item_o,
    output logic    refund_o,
    output credit_t refund_amt_o,
    output logic    reject_o,
    output credit_t credit_o
);

    state_e  state_q;
    credit_t credit_q;
    logic    afford;

    assign afford   = (credit_q >= price_i);
    assign credit_o = credit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            credit_q     <= '0;
            vend_o       <= 1'b0;
            vend_item_o  <= '0;
            refund_o     <= 1'b0;
            refund_amt_o <= '0;
            reject_o     <= 1'b0;
        end else begin
            vend_o       <= 1'b0;
            vend_item_o  <= '0;
            refund_o     <= 1'b0;
            refund_amt_o <= '0;
            reject_o     <= 1'b0;
            case (req_i.cmd)
                CMD_COIN: begin
                    credit_q <= sat_add(credit_q, req_i.amt);
                    state_q  <= ST_SESSION;
                end
                CMD_SEL: begin
                    if (afford) begin
                        credit_q    <= credit_q - price_i;
                        vend_o      <= 1'b1;
                        vend_item_o <= req_i.item;
                    end else begin
                        reject_o <= 1'b1;
                    end
                end
                CMD_END: begin
                    if (state_q == ST_SESSION) begin
                        refund_o     <= 1'b1;
                        refund_amt_o <= credit_q;
                        credit_q     <= '0;
                        state_q      <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1 R2
    coin_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_COIN) |=> (credit_q >= $past(credit_q)));

    // R3
    vend_debit_chk: assert property (@(posedge clk) disable iff (rst)
        vend_o |-> (credit_q == credit_t'($past(credit_q) - $past(price_i))));

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> (credit_q == $past(credit_q)));

    // R5
    refund_clear_chk: assert property (@(posedge clk) disable iff (rst)
        refund_o |-> (credit_q == '0 && refund_amt_o == $past(credit_q)));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vend_o, refund_o, reject_o}));

    // R8
    refund_single_chk: assert property (@(posedge clk) disable iff (rst)
        refund_o |=> !refund_o);

endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_stb_i,
    input  logic [CREDIT_W-1:0] coin_amt_i,
    input  logic                sel_stb_i,
    input  logic [ITEM_W-1:0]   sel_code_i,
    input  logic                end_stb_i,
    output logic                vend_o,
    output logic [ITEM_W-1:0]   vend_item_o,
    output logic                refund_o,
    output logic [CREDIT_W-1:0] refund_amt_o,
    output logic                reject_o,
    output logic [CREDIT_W-1:0] credit_o
);

    req_t    req;
    credit_t price;

    vend_arbiter u_arb (
        .coin_stb_i (coin_stb_i),
        .coin_amt_i (coin_amt_i),
        .sel_stb_i  (sel_stb_i),
        .sel_code_i (sel_code_i),
        .end_stb_i  (end_stb_i),
        .req_o      (req)
    );

    vend_price_lut u_lut (
        .code_i  (req.item),
        .price_o (price)
    );

    vend_credit_unit u_cu (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .price_i      (price),
        .vend_o       (vend_o),
        .vend_item_o  (vend_item_o),
        .refund_o     (refund_o),
        .refund_amt_o (refund_amt_o),
        .reject_o     (reject_o),
        .credit_o     (credit_o)
    );

    // R7
    end_wins_chk: assert property (@(posedge clk) disable iff (rst)
        end_stb_i |=> (!vend_o && !reject_o));

endmodule

// File: tb/vend_credit_ctrl_bench.sv
module vend_credit_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       coin_stb, sel_stb, end_stb;
    logic [7:0] coin_amt;
    logic [1:0] sel_code;
    logic       vend, refund, reject;
    logic [1:0] vend_item;
    logic [7:0] refund_amt, credit;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vend_credit_ctrl u_vend_credit_ctrl (
        .clk          (clk),
        .rst          (rst),
        .coin_stb_i   (coin_stb),
        .coin_amt_i   (coin_amt),
        .sel_stb_i    (sel_stb),
        .sel_code_i   (sel_code),
        .end_stb_i    (end_stb),
        .vend_o       (vend),
        .vend_item_o  (vend_item),
        .refund_o     (refund),
        .refund_amt_o (refund_amt),
        .reject_o     (reject),
        .credit_o     (credit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of strobes, then sample just after the edge
    task automatic step(input logic c, input int amt, input logic s, input int code, input logic e);
        @(negedge clk);
        coin_stb = c; coin_amt = 8'(amt);
        sel_stb  = s; sel_code = 2'(code);
        end_stb  = e;
        @(posedge clk);
        #1;
        @(negedge clk);
        coin_stb = 1'b0; sel_stb = 1'b0; end_stb = 1'b0;
    endtask

    task automatic expect_out(input string req, input int v, input int item, input int rf,
                              input int ramt, input int rj, input int cr);
        chk(req, "vend", int'(vend), v);
        chk(req, "vend_item", int'(vend_item), item);
        chk(req, "refund", int'(refund), rf);
        chk(req, "refund_amt", int'(refund_amt), ramt);
        chk(req, "reject", int'(reject), rj);
        chk(req, "credit", int'(credit), cr);
    endtask

    task automatic idle_cycle_check(input string req, input int cr);
        @(posedge clk); #1;
        expect_out(req, 0, 0, 0, 0, 0, cr);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R9", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_session36;
        step(1, 20, 0, 0, 0); expect_out("R1", 0, 0, 0, 0, 0, 20);
        step(1, 16, 0, 0, 0); expect_out("R1", 0, 0, 0, 0, 0, 36);
        step(0, 0, 1, 0, 0);  expect_out("R3 R6 R10", 1, 0, 0, 0, 0, 23);
        idle_cycle_check("R8", 23);
        step(0, 0, 1, 0, 0);  expect_out("R3 R10", 1, 0, 0, 0, 0, 10);
        step(0, 0, 1, 1, 0);  expect_out("R4 R10", 0, 0, 0, 0, 1, 10);
        idle_cycle_check("R8", 10);
        step(0, 0, 0, 0, 1);  expect_out("R5", 0, 0, 1, 10, 0, 0);
        idle_cycle_check("R8", 0);
    endtask

    task automatic t_exact;
        step(1, 7, 0, 0, 0);  expect_out("R1", 0, 0, 0, 0, 0, 7);
        step(0, 0, 1, 3, 0);  expect_out("R4 R6", 0, 0, 0, 0, 1, 7);
        step(0, 0, 1, 2, 0);  expect_out("R3 R6", 1, 2, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);  expect_out("R5", 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1);  expect_out("R5 idle", 0, 0, 0, 0, 0, 0);
        step(1, 11, 0, 0, 0); expect_out("R1", 0, 0, 0, 0, 0, 11);
        step(0, 0, 1, 1, 0);  expect_out("R3 R6", 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);  expect_out("R5", 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_saturate;
        step(1, 200, 0, 0, 0); expect_out("R1", 0, 0, 0, 0, 0, 200);
        step(1, 100, 0, 0, 0); expect_out("R2", 0, 0, 0, 0, 0, 255);
        step(1, 1, 0, 0, 0);   expect_out("R2", 0, 0, 0, 0, 0, 255);
        step(0, 0, 1, 3, 0);   expect_out("R3 R6", 1, 3, 0, 0, 0, 235);
        step(0, 0, 0, 0, 1);   expect_out("R5", 0, 0, 1, 235, 0, 0);
    endtask

    task automatic t_priority;
        step(1, 5, 0, 0, 0);   expect_out("R1", 0, 0, 0, 0, 0, 5);
        step(1, 50, 1, 2, 1);  expect_out("R7", 0, 0, 1, 5, 0, 0);
        step(1, 20, 0, 0, 0);  expect_out("R1", 0, 0, 0, 0, 0, 20);
        step(1, 9, 1, 2, 0);   expect_out("R7", 1, 2, 0, 0, 0, 13);
        step(1, 40, 1, 3, 0);  expect_out("R7 R4", 0, 0, 0, 0, 1, 13);
        step(0, 0, 0, 0, 1);   expect_out("R5 R7", 0, 0, 1, 13, 0, 0);
        rst = 1'b1;
        step(1, 30, 0, 0, 0);  expect_out("R9", 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        step(0, 0, 0, 0, 1);   expect_out("R9 R5", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        coin_stb = 1'b0; sel_stb = 1'b0; end_stb = 1'b0;
        coin_amt = '0;   sel_code = '0;  rst = 1'b1;
        t_reset;
        t_session36;
        t_exact;
        t_saturate;
        t_priority;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule